// File: doc/BRIEF.md
# Segmented Data-Memory Address Unit

This block sits between the operand path of a small 8-bit processor and a 512-byte data RAM. Each cycle it can take one access. The access names an 8-bit logical address, either directly or through one of three pointer registers. The unit turns that address into a 9-bit physical RAM address, gates the RAM strobes and returns the read data.

Four address registers live inside the unit and appear at the very top of the logical space: the alternate pointer X, the stack pointer SP, the primary pointer B and the segment register S. Logical addresses in the upper half go to one fixed 128-byte RAM block. Addresses in the lower half go through S, which selects one 128-byte window out of 256. Only as many windows as the RAM can hold are backed by storage. An indirect access through B or X can step its pointer up or down by one afterwards.

The unit is a single-cycle datapath with no sequencing state. The only storage is the register file. Each of its registers has three sources, chosen in fixed priority order: reset value, bus write, and post-update (B and X only).

Top module: `seg_addr_unit`

## Requirements
- R1: After reset, direct reads of 0xFC, 0xFD, 0xFE and 0xFF return X=0x00, SP=0x6F, B=0x00 and S=0x00.
- R2: A logical address from 0x80 to 0xFB maps to physical address (address − 0x80), whatever the value of S, with `ram_en` high.
- R3: A logical address from 0x00 to 0x7F maps to physical address 0x80 + S·128 + address when S is 0, 1 or 2, so windows never overlap one another or the upper block.
- R4: For S of 3 or more, a lower-half access does not raise `ram_en` or `ram_we`, and a read returns 0x00.
- R5: Logical addresses 0xFC (X), 0xFD (SP), 0xFE (B) and 0xFF (S) are registers: writes load them, reads return their live values, and `ram_en` stays low.
- R6: `acc_mode` selects the logical address: 0 uses `acc_addr`, 1 uses B, 2 uses X, 3 uses SP. The result goes through the same mapping as R2 to R5.
- R7: With `acc_mode` 1 or 2, `acc_upd` 1 adds one to the selected pointer and 2 subtracts one, both modulo 256, at the end of the access. Values 0 and 3, and modes 0 and 3, leave the pointers unchanged.
- R8: When an access writes to the same pointer that it post-updates, the written value is kept and the step is dropped.
- R9: With `acc_en` low, `ram_en` and `ram_we` stay low and no register changes.
- R10: `ram_we` is high only when `acc_wr` is high and `ram_en` is high, and `ram_wdata` carries `acc_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 2 | Address source: 0 direct, 1 via B, 2 via X, 3 via SP |
| acc_upd | input | 2 | Pointer step: 1 increment, 2 decrement, 0/3 none |
| acc_addr | input | 8 | Direct logical address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, combinational |
| ram_addr | output | 9 | Physical RAM address |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid in the same cycle as `ram_addr` |

## Verification
The properties assume that the RAM answers combinationally, so `acc_rdata` is judged in the same cycle as `ram_addr`. They also assume that `acc_mode` and `acc_upd` are known whenever `acc_en` is high. The stepping property further assumes that the pointer it watches is not being written through its own address at the same time. The stimulus meets these conditions by construction. Its bench RAM is a combinational array. Every access drives all control fields to defined values. The write-precedence corner (R8) is driven only on purpose, and the property excludes it explicitly. The random phase covers all modes, both directions, window values past the top of the RAM and pointer wrap.

// File: rtl/sau_pkg.sv
package sau_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] LA_X  = 8'hFC;
    localparam logic [ADDR_W-1:0] LA_SP = 8'hFD;
    localparam logic [ADDR_W-1:0] LA_B  = 8'hFE;
    localparam logic [ADDR_W-1:0] LA_S  = 8'hFF;

    // register-file slot order follows the low two address bits
    localparam int SLOT_X  = 0;
    localparam int SLOT_SP = 1;
    localparam int SLOT_B  = 2;
    localparam int SLOT_S  = 3;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_VIA_B  = 2'd1,
        MODE_VIA_X  = 2'd2,
        MODE_VIA_SP = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_INC   = 2'd1,
        UPD_DEC   = 2'd2,
        UPD_NONE2 = 2'd3
    } upd_e;

endpackage

// File: rtl/sau_xlate.sv
module sau_xlate
    import sau_pkg::*;
#(
    parameter int RAM_BYTES = 512
) (
    input  logic [ADDR_W-1:0] la,
    input  logic [ADDR_W-1:0] seg,
    output logic              is_reg,
    output logic              ram_ok,
    output logic [$clog2(RAM_BYTES)-1:0] phys
);
    localparam int PHYS_W  = $clog2(RAM_BYTES);
    localparam int OFF_W   = ADDR_W - 1;
    localparam int WIN_B   = 2 ** OFF_W;
    localparam int N_WIN   = RAM_BYTES / WIN_B - 1;
    localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(N_WIN);

    logic [ADDR_W+OFF_W:0] wide;

    always_comb begin
        is_reg = (la >= LA_X);
        wide   = '0;
        if (la[ADDR_W-1]) begin
            wide   = (ADDR_W+OFF_W+1)'(la[OFF_W-1:0]);
            ram_ok = !is_reg;
        end else begin
            wide   = {({1'b0, seg} + (ADDR_W+1)'(1)), la[OFF_W-1:0]};
            ram_ok = ({1'b0, seg} < WIN_LIM);
        end
        phys = wide[PHYS_W-1:0];
    end

endmodule

// File: rtl/sau_ptrs.sv
module sau_ptrs
    import sau_pkg::*;
#(
    parameter logic [DATA_W-1:0] SP_INIT = 8'h6F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step_en,
    input  logic [1:0]        step_slot,
    input  logic              step_down,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] sp_q,
    output logic [DATA_W-1:0] b_q,
    output logic [DATA_W-1:0] s_q
);
    localparam int N_SLOT = 4;

    logic [DATA_W-1:0] slot_q [N_SLOT];

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        localparam logic [DATA_W-1:0] RST_V = (i == SLOT_SP) ? SP_INIT : '0;
        localparam bit STEPS = (i == SLOT_B) || (i == SLOT_X);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= RST_V;
            end else if (wr_en && (wr_slot == 2'(i))) begin
                slot_q[i] <= wr_data;
            end else if (STEPS && step_en && (step_slot == 2'(i))) begin
                slot_q[i] <= step_down ? slot_q[i] - 8'd1 : slot_q[i] + 8'd1;
            end
        end
    end

    assign x_q  = slot_q[SLOT_X];
    assign sp_q = slot_q[SLOT_SP];
    assign b_q  = slot_q[SLOT_B];
    assign s_q  = slot_q[SLOT_S];

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import sau_pkg::*;
#(
    parameter int                RAM_BYTES = 512,
    parameter logic [DATA_W-1:0] SP_INIT   = 8'h6F
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_en,
    input  logic                         acc_wr,
    input  logic [1:0]                   acc_mode,
    input  logic [1:0]                   acc_upd,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic [DATA_W-1:0]            acc_wdata,
    output logic [DATA_W-1:0]            acc_rdata,
    output logic [$clog2(RAM_BYTES)-1:0] ram_addr,
    output logic                         ram_en,
    output logic                         ram_we,
    output logic [DATA_W-1:0]            ram_wdata,
    input  logic [DATA_W-1:0]            ram_rdata
);
    localparam int PHYS_W = $clog2(RAM_BYTES);

    mode_e             mode;
    upd_e              upd;
    logic [ADDR_W-1:0] la;
    logic              is_reg;
    logic              ram_ok;
    logic [PHYS_W-1:0] phys;
    logic [DATA_W-1:0] x_q, sp_q, b_q, s_q;
    logic [DATA_W-1:0] reg_rd;
    logic              step_en;

    assign mode = mode_e'(acc_mode);
    assign upd  = upd_e'(acc_upd);

    always_comb begin
        unique case (mode)
            MODE_DIRECT: la = acc_addr;
            MODE_VIA_B:  la = b_q;
            MODE_VIA_X:  la = x_q;
            MODE_VIA_SP: la = sp_q;
        endcase
    end

    sau_xlate #(.RAM_BYTES(RAM_BYTES)) u_xlate (
        .la     (la),
        .seg    (s_q),
        .is_reg (is_reg),
        .ram_ok (ram_ok),
        .phys   (phys)
    );

    assign step_en = acc_en
                   && ((mode == MODE_VIA_B) || (mode == MODE_VIA_X))
                   && ((upd == UPD_INC) || (upd == UPD_DEC));

    sau_ptrs #(.SP_INIT(SP_INIT)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_en && acc_wr && is_reg),
        .wr_slot   (la[1:0]),
        .wr_data   (acc_wdata),
        .step_en   (step_en),
        .step_slot ((mode == MODE_VIA_B) ? 2'(SLOT_B) : 2'(SLOT_X)),
        .step_down (upd == UPD_DEC),
        .x_q       (x_q),
        .sp_q      (sp_q),
        .b_q       (b_q),
        .s_q       (s_q)
    );

    always_comb begin
        unique case (la[1:0])
            2'd0: reg_rd = x_q;
            2'd1: reg_rd = sp_q;
            2'd2: reg_rd = b_q;
            2'd3: reg_rd = s_q;
        endcase
    end

    assign ram_addr  = phys;
    assign ram_en    = acc_en && ram_ok;
    assign ram_we    = acc_en && ram_ok && acc_wr;
    assign ram_wdata = acc_wdata;
    assign acc_rdata = is_reg ? reg_rd : (ram_ok ? ram_rdata : '0);

endmodule

module sau_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_en,
    input logic       acc_wr,
    input logic [1:0] acc_mode,
    input logic [1:0] acc_upd,
    input logic [7:0] acc_addr,
    input logic [7:0] acc_rdata,
    input logic [8:0] ram_addr,
    input logic       ram_en,
    input logic       ram_we,
    input logic [7:0] b_q,
    input logic [7:0] x_q
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (!ram_en && !ram_we));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!acc_en) |-> ($stable(b_q) && $stable(x_q)));

    p_we_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (acc_wr && ram_en));

    p_reg_no_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'd0 && acc_addr >= 8'hFC) |-> !ram_en);

    p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'd0 && acc_addr[7] && acc_addr < 8'hFC)
        |-> (ram_en && ram_addr == {2'b00, acc_addr[6:0]}));

    p_oob_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_mode == 2'd0 && !acc_addr[7] && !ram_en)
        |-> (acc_rdata == 8'h00));

    p_b_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'd1 && acc_upd == 2'd1 && !(acc_wr && b_q >= 8'hFC))
        |=> (b_q == $past(b_q) + 8'd1));

    p_x_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'd2 && acc_upd == 2'd2 && !(acc_wr && x_q >= 8'hFC))
        |=> (x_q == $past(x_q) - 8'd1));

endmodule

bind seg_addr_unit sau_checker u_chk (.*);

// File: tb/sim_seg_addr_unit.sv
module sim_seg_addr_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic [1:0] acc_mode = 2'd0;
    logic [1:0] acc_upd = 2'd0;
    logic [7:0] acc_addr = 8'd0;
    logic [7:0] acc_wdata = 8'd0;
    logic [7:0] acc_rdata;
    logic [8:0] ram_addr;
    logic       ram_en;
    logic       ram_we;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata;

    logic [7:0] mem [512];

    int checks = 0;
    int fails  = 0;

    // reference model state
    int mref [512];
    int mX, mSP, mB, mS;

    always #2 clk = ~clk;

    seg_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_mode(acc_mode), .acc_upd(acc_upd), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ram_addr(ram_addr),
        .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    assign ram_rdata = mem[ram_addr];

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int reg_of(input int la);
        case (la)
            8'hFC:   return mX;
            8'hFD:   return mSP;
            8'hFE:   return mB;
            default: return mS;
        endcase
    endfunction

    task automatic acc(input bit en, input bit wr, input int md, input int up,
                       input int ad, input int wd, input string tag);
        int  la, phys, erd, oB, oX;
        bit  isreg, ok;
        @(negedge clk);
        acc_en = en; acc_wr = wr; acc_mode = 2'(md); acc_upd = 2'(up);
        acc_addr = 8'(ad); acc_wdata = 8'(wd);
        #1;
        la = (md == 0) ? ad : (md == 1) ? mB : (md == 2) ? mX : mSP;
        isreg = (la >= 8'hFC);
        ok = 1'b0; phys = 0; erd = 0;
        if (isreg) erd = reg_of(la);
        else if (la >= 8'h80) begin ok = 1'b1; phys = la - 8'h80; end
        else if (mS < 3) begin ok = 1'b1; phys = 128 + mS * 128 + la; end
        if (ok) erd = mref[phys];
        chk(tag, "ram_en", int'(ram_en), int'(en && ok));
        chk(tag, "ram_we", int'(ram_we), int'(en && ok && wr));
        if (en && ok) chk(tag, "ram_addr", int'(ram_addr), phys);
        if (en && ok && wr) chk(tag, "ram_wdata", int'(ram_wdata), wd);
        if (en && !wr) chk(tag, "acc_rdata", int'(acc_rdata), erd);
        @(posedge clk);
        oB = mB; oX = mX;
        if (en && wr) begin
            if (ok) mref[phys] = wd & 255;
            if (isreg) begin
                case (la)
                    8'hFC:   mX  = wd & 255;
                    8'hFD:   mSP = wd & 255;
                    8'hFE:   mB  = wd & 255;
                    default: mS  = wd & 255;
                endcase
            end
        end
        if (en && (up == 1 || up == 2)) begin
            if (md == 1 && !(wr && la == 8'hFE)) mB = (oB + (up == 1 ? 1 : 255)) % 256;
            if (md == 2 && !(wr && la == 8'hFC)) mX = (oX + (up == 1 ? 1 : 255)) % 256;
        end
    endtask

    task automatic rd(input int ad, input string tag);
        acc(1'b1, 1'b0, 0, 0, ad, 0, tag);
    endtask

    task automatic wrd(input int ad, input int wd, input string tag);
        acc(1'b1, 1'b1, 0, 0, ad, wd, tag);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'h00;
            mref[i] = 0;
        end
        mX = 0; mSP = 8'h6F; mB = 0; mS = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(8'hFC, "R1"); rd(8'hFD, "R1"); rd(8'hFE, "R1"); rd(8'hFF, "R1");

        // R2: upper half fixed, independent of S
        wrd(8'h80, 8'hA1, "R2"); wrd(8'hFB, 8'hA2, "R2"); wrd(8'hC3, 8'hA3, "R2");
        wrd(8'hFF, 8'd2, "R5");
        rd(8'h80, "R2"); rd(8'hFB, "R2"); rd(8'hC3, "R2");

        // R3: three windows are distinct
        for (int s = 0; s < 3; s++) begin
            wrd(8'hFF, s, "R5");
            wrd(8'h00, 8'h10 + s, "R3");
            wrd(8'h7F, 8'h20 + s, "R3");
        end
        for (int s = 0; s < 3; s++) begin
            wrd(8'hFF, s, "R5");
            rd(8'h00, "R3"); rd(8'h7F, "R3");
        end

        // R4: windows beyond the RAM
        wrd(8'hFF, 8'd3, "R5");
        wrd(8'h05, 8'h55, "R4"); rd(8'h05, "R4");
        wrd(8'hFF, 8'd200, "R5");
        rd(8'h7F, "R4"); rd(8'hFF, "R5");
        wrd(8'hFF, 8'd0, "R5");
        rd(8'h05, "R4");

        // R5: register writes and live reads
        wrd(8'hFC, 8'h90, "R5"); wrd(8'hFD, 8'h33, "R5"); wrd(8'hFE, 8'h81, "R5");
        rd(8'hFC, "R5"); rd(8'hFD, "R5"); rd(8'hFE, "R5");

        // R6: indirect through each pointer
        acc(1'b1, 1'b0, 1, 0, 0, 0, "R6");
        acc(1'b1, 1'b1, 2, 0, 0, 8'h77, "R6");
        acc(1'b1, 1'b0, 2, 0, 0, 0, "R6");
        acc(1'b1, 1'b1, 3, 0, 0, 8'h44, "R6");
        acc(1'b1, 1'b0, 3, 1, 0, 0, "R6");
        rd(8'h33, "R6"); rd(8'hFD, "R7");

        // R7: stepping and wrap
        wrd(8'hFE, 8'hFB, "R7");
        acc(1'b1, 1'b0, 1, 1, 0, 0, "R7");
        rd(8'hFE, "R7");
        wrd(8'hFC, 8'h00, "R7");
        acc(1'b1, 1'b1, 2, 2, 0, 8'h5A, "R7");
        rd(8'hFC, "R7");
        wrd(8'hFE, 8'hFF, "R7");
        wrd(8'hFF, 8'd0, "R7");
        wrd(8'hFC, 8'h10, "R7");
        acc(1'b1, 1'b0, 2, 1, 0, 0, "R7");
        acc(1'b1, 1'b0, 2, 3, 0, 0, "R7");
        acc(1'b1, 1'b0, 0, 1, 8'h90, 0, "R7");
        rd(8'hFC, "R7");

        // R8: write to own pointer beats the step
        wrd(8'hFE, 8'hFE, "R8");
        acc(1'b1, 1'b1, 1, 1, 0, 8'h42, "R8");
        rd(8'hFE, "R8");
        wrd(8'hFC, 8'hFC, "R8");
        acc(1'b1, 1'b1, 2, 2, 0, 8'h09, "R8");
        rd(8'hFC, "R8");

        // R9: disabled access changes nothing
        acc(1'b0, 1'b1, 0, 0, 8'hFE, 8'hEE, "R9");
        acc(1'b0, 1'b1, 1, 1, 0, 8'hEE, "R9");
        acc(1'b0, 1'b1, 0, 0, 8'h88, 8'hEE, "R9");
        rd(8'hFE, "R9"); rd(8'hFC, "R9"); rd(8'h88, "R9");

        // R10 and mixed traffic
        for (int i = 0; i < 600; i++) begin
            int md, ad;
            md = int'($urandom_range(0, 3));
            ad = int'($urandom_range(0, 255));
            if (ad == 8'hFF && ($urandom_range(0, 3) != 0)) ad = 8'hFE;
            acc(($urandom_range(0, 7) != 0), $urandom_range(0, 1), md,
                int'($urandom_range(0, 3)), ad, int'($urandom_range(0, 255)), "R10");
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule